// File: doc/BRIEF.md
# Stereo Digital Volume with Paired Gain Commit

This block scales a signed stereo PCM stream by a per-channel attenuation code. Each channel owns an 8-bit code that selects a gain between -127 dB and 0 dB in half-decibel steps, plus a hard mute at code zero. Software writes codes through a small register port. Each write lands in a staging copy, and nothing reaches the audio path until a write carries the commit flag.

A write with the commit flag, to either channel's address, moves both staged codes into the active gains on the same clock edge. A balance change therefore never reaches the output as a left-only or right-only step. Each code maps to a fixed-point multiplier held in a table that is computed at elaboration. The scaled sample is rounded, saturated and registered, so the output appears one clock after the input.

Top module: `svol_top`

## Requirements
- R1: After reset, both staged codes and both active codes are 0xFF, read-back at addresses 0 and 1 returns 0xFF, and outValid is 0.
- R2: While a channel's active code is 0x00, every sample that channel outputs is exactly zero.
- R3: While a channel's active code is 0xFF, that channel outputs its input sample unchanged.
- R4: For an active code c from 1 to 255, the gain is G = round(10^((c-255)/40) * 2^23). The output is (x*G + 2^22) shifted arithmetically right by 23 bits, then saturated to the 24-bit signed range.
- R5: A write whose bit 8 (the commit flag) is 0 changes only the addressed staged code, and that code reads back at once. The active gains and the audio output stay as they were.
- R6: A write with bit 8 set, to address 0 (left) or address 1 (right), first updates the addressed staged code. It then copies both staged codes into the active gains at the same clock edge.
- R7: A sample accepted in the same cycle as a commit is scaled with the gains that were active before that commit. Samples accepted from the next cycle onward use the new gains.
- R8: outValid equals inValid of the previous cycle. outLeft and outRight change only one cycle after an accepted sample, and otherwise hold their values.
- R9: Writes to addresses 2 and 3 are ignored, even with bit 8 set, and read-back at those addresses returns 0. The commit flag itself is never stored and never appears in read-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 left, 1 right) |
| regWrData | input | 9 | Write data: bits 7:0 code, bit 8 commit flag |
| regRdData | output | 8 | Staged code at regAddr (combinational) |
| inValid | input | 1 | Input sample valid |
| inLeft | input | 24 | Left input sample, signed |
| inRight | input | 24 | Right input sample, signed |
| outValid | output | 1 | Output sample valid |
| outLeft | output | 24 | Left scaled sample, signed |
| outRight | output | 24 | Right scaled sample, signed |

## Verification
A commit and an accepted sample can fall on the same clock edge. This is the one collision where the old gain and the new gain are both in play. The bench drives a commit write together with a valid sample at several points, and for both channels it requires that sample to come out at the old gain and the next sample at the new one. A behavioural model tracks staged and active codes and computes every expected output from the gain formula, so that it can judge the collision case.

// File: rtl/svol_pkg.sv
package svol_pkg;
  localparam int CODE_W = 8;
  localparam int WDATA_W = CODE_W + 1;

  typedef struct packed {
    logic              commit;
    logic [CODE_W-1:0] codeL;
    logic [CODE_W-1:0] codeR;
  } svol_ctl_t;
endpackage

// File: rtl/svol_ctrl.sv
module svol_ctrl
  import svol_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [WDATA_W-1:0] regWrData,
  output logic [CODE_W-1:0]  regRdData,
  output svol_ctl_t          ctl
);
  localparam logic [ADDR_W-1:0] ADDR_LEFT  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_RIGHT = ADDR_W'(1);
  localparam int               FLAG_BIT   = CODE_W;

  logic [CODE_W-1:0] stagedL, stagedR;
  logic              hitL, hitR;

  assign hitL = regWrEn && (regAddr == ADDR_LEFT);
  assign hitR = regWrEn && (regAddr == ADDR_RIGHT);

  always_comb begin
    ctl.codeL  = hitL ? regWrData[CODE_W-1:0] : stagedL;
    ctl.codeR  = hitR ? regWrData[CODE_W-1:0] : stagedR;
    ctl.commit = (hitL || hitR) && regWrData[FLAG_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stagedL <= '1;
      stagedR <= '1;
    end else begin
      stagedL <= ctl.codeL;
      stagedR <= ctl.codeR;
    end
  end

  always_comb begin
    if (regAddr == ADDR_LEFT)       regRdData = stagedL;
    else if (regAddr == ADDR_RIGHT) regRdData = stagedR;
    else                            regRdData = '0;
  end
endmodule

// File: rtl/svol_gain_rom.sv
module svol_gain_rom #(
  parameter int CODE_W = 8,
  parameter int GAIN_W = 24,
  parameter int FRAC   = 23
) (
  input  logic [CODE_W-1:0] code,
  output logic [GAIN_W-1:0] gain
);
  localparam int DEPTH = 2 ** CODE_W;

  function automatic logic [GAIN_W-1:0] gainOf(input int c);
    real db;
    real lin;
    if (c == 0) return '0;
    db  = real'(c - (DEPTH - 1)) * 0.5;
    lin = 10.0 ** (db / 20.0);
    return GAIN_W'($rtoi(lin * (2.0 ** FRAC) + 0.5));
  endfunction

  logic [GAIN_W-1:0] romArr [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam logic [GAIN_W-1:0] ENTRY = gainOf(i);
    assign romArr[i] = ENTRY;
  end

  assign gain = romArr[code];
endmodule

// File: rtl/svol_datapath.sv
module svol_datapath
  import svol_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int GAIN_W   = 24,
  parameter int FRAC     = 23
) (
  input  logic                clk,
  input  logic                rstN,
  input  svol_ctl_t           ctl,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outLeft,
  output logic [SAMPLE_W-1:0] outRight,
  output logic [CODE_W-1:0]   activeL,
  output logic [CODE_W-1:0]   activeR
);
  localparam int PW = SAMPLE_W + GAIN_W + 1;
  localparam logic signed [PW-1:0] MAXV = PW'((longint'(1) << (SAMPLE_W - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);
  localparam logic signed [PW-1:0] HALF = PW'(longint'(1) << (FRAC - 1));

  logic [CODE_W-1:0]   activeCode [2];
  logic [SAMPLE_W-1:0] laneIn     [2];
  logic [SAMPLE_W-1:0] laneOut    [2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeCode[0] <= '1;
      activeCode[1] <= '1;
    end else if (ctl.commit) begin
      activeCode[0] <= ctl.codeL;
      activeCode[1] <= ctl.codeR;
    end
  end

  assign laneIn[0] = inLeft;
  assign laneIn[1] = inRight;

  for (genvar ch = 0; ch < 2; ch++) begin : g_lane
    logic [GAIN_W-1:0]     gain;
    logic signed [PW-1:0]  xs, gs, prod, shifted;
    logic [SAMPLE_W-1:0]   satVal;

    svol_gain_rom #(.CODE_W(CODE_W), .GAIN_W(GAIN_W), .FRAC(FRAC)) u_rom (
      .code(activeCode[ch]),
      .gain(gain)
    );

    always_comb begin
      xs      = PW'($signed(laneIn[ch]));
      gs      = $signed({{(PW-GAIN_W){1'b0}}, gain});
      prod    = xs * gs;
      shifted = (prod + HALF) >>> FRAC;
      if (shifted > MAXV)      satVal = SAMPLE_W'(MAXV);
      else if (shifted < MINV) satVal = SAMPLE_W'(MINV);
      else                     satVal = SAMPLE_W'(shifted);
    end

    always_ff @(posedge clk) begin
      if (!rstN)        laneOut[ch] <= '0;
      else if (inValid) laneOut[ch] <= satVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  assign outLeft  = laneOut[0];
  assign outRight = laneOut[1];
  assign activeL  = activeCode[0];
  assign activeR  = activeCode[1];
endmodule

// File: rtl/svol_top.sv
module svol_top
  import svol_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int GAIN_W   = 24,
  parameter int FRAC     = 23,
  parameter int ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [WDATA_W-1:0]  regWrData,
  output logic [CODE_W-1:0]   regRdData,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outLeft,
  output logic [SAMPLE_W-1:0] outRight
);
  svol_ctl_t         ctlBus;
  logic [CODE_W-1:0] activeL, activeR;

  svol_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .ctl(ctlBus)
  );

  svol_datapath #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .FRAC(FRAC)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .inValid(inValid),
    .inLeft(inLeft), .inRight(inRight), .outValid(outValid),
    .outLeft(outLeft), .outRight(outRight),
    .activeL(activeL), .activeR(activeR)
  );
endmodule

// File: rtl/svol_chk.sv
module svol_chk #(
  parameter int SAMPLE_W = 24,
  parameter int ADDR_W   = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWrEn,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [8:0]          regWrData,
  input logic                inValid,
  input logic [SAMPLE_W-1:0] inLeft,
  input logic [SAMPLE_W-1:0] inRight,
  input logic                outValid,
  input logic [SAMPLE_W-1:0] outLeft,
  input logic [SAMPLE_W-1:0] outRight,
  input logic [7:0]          activeL,
  input logic [7:0]          activeR
);
  logic commitWr;
  assign commitWr = regWrEn && regWrData[8] && (regAddr < ADDR_W'(2));

  // R8: valid is delayed by exactly one clock
  a_r8_valid_follow: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r8_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(outLeft) && $stable(outRight)));

  // R2: muted channel yields zero
  a_r2_mute_left: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && activeL == 8'h00) |=> (outLeft == '0));
  a_r2_mute_right: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && activeR == 8'h00) |=> (outRight == '0));

  // R3: full-scale code passes data unchanged
  a_r3_unity_left: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && activeL == 8'hFF) |=> (outLeft == $past(inLeft)));

  // R5/R9: without a valid commit write, active gains hold
  a_r5_hold_active: assert property (@(posedge clk) disable iff (!rstN)
    !commitWr |=> ($stable(activeL) && $stable(activeR)));

  // R6: commit to left loads the written code into the active left gain
  a_r6_commit_left: assert property (@(posedge clk) disable iff (!rstN)
    (commitWr && regAddr == ADDR_W'(0)) |=> (activeL == $past(regWrData[7:0])));
  a_r6_commit_right: assert property (@(posedge clk) disable iff (!rstN)
    (commitWr && regAddr == ADDR_W'(1)) |=> (activeR == $past(regWrData[7:0])));
endmodule

bind svol_top svol_chk #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .inValid(inValid), .inLeft(inLeft),
  .inRight(inRight), .outValid(outValid), .outLeft(outLeft),
  .outRight(outRight), .activeL(activeL), .activeR(activeR)
);

// File: tb/svol_top_tb.sv
module svol_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [8:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        inValid = 1'b0;
  logic [23:0] inLeft = '0, inRight = '0;
  logic        outValid;
  logic [23:0] outLeft, outRight;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // behavioural model state
  int     mStL = 255, mStR = 255, mActL = 255, mActR = 255;
  longint expL = 0, expR = 0;
  bit     expV = 0;

  always #2.5 clk = ~clk;

  svol_top u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .inValid(inValid),
    .inLeft(inLeft), .inRight(inRight), .outValid(outValid),
    .outLeft(outLeft), .outRight(outRight)
  );

  function automatic longint refScale(longint x, int c);
    real    gr;
    longint g, p;
    if (c == 0) return 0;
    gr = 10.0 ** ((c - 255) / 40.0);
    g  = longint'($floor(gr * 8388608.0 + 0.5));
    p  = (x * g + 64'sd4194304) >>> 23;
    if (p > 8388607)  p = 8388607;
    if (p < -8388608) p = -8388608;
    return p;
  endfunction

  task automatic check(string tag, longint act, longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic drive(bit we, int addr, int data, bit v, int l, int r);
    regWrEn   = we;
    regAddr   = 2'(addr);
    regWrData = 9'(data);
    inValid   = v;
    inLeft    = 24'(l);
    inRight   = 24'(r);
  endtask

  // one clock: model the edge, then compare after it
  task automatic step(string tag);
    int  rd;
    bit  commit;
    if (inValid) begin
      expL = refScale(longint'($signed(inLeft)), mActL);
      expR = refScale(longint'($signed(inRight)), mActR);
    end
    expV = inValid;
    @(posedge clk);
    commit = 0;
    if (regWrEn && regAddr == 2'd0) begin mStL = int'(regWrData[7:0]); commit = regWrData[8]; end
    if (regWrEn && regAddr == 2'd1) begin mStR = int'(regWrData[7:0]); commit = regWrData[8]; end
    if (commit) begin mActL = mStL; mActR = mStR; end
    @(negedge clk);
    check({tag, " valid"}, longint'(outValid), longint'(expV));
    check({tag, " left"}, longint'($signed(outLeft)), expL);
    check({tag, " right"}, longint'($signed(outRight)), expR);
    rd = (regAddr == 2'd0) ? mStL : (regAddr == 2'd1) ? mStR : 0;
    check({tag, " readback"}, longint'(regRdData), longint'(rd));
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1 outValid", longint'(outValid), 0);
    regAddr = 2'd0; #0.1;
    check("R1 readback left", longint'(regRdData), 255);
    regAddr = 2'd1; #0.1;
    check("R1 readback right", longint'(regRdData), 255);

    // R3: unity pass-through, including extremes
    drive(0, 0, 0, 1, 8388607, -8388608); step("R3 extremes");
    for (int i = 0; i < 8; i++) begin
      drive(0, 1, 0, 1, int'($urandom), int'($urandom)); step("R3 random");
    end

    // R5: staged write without commit leaves output at unity
    drive(1, 0, 9'h000, 1, 12345, -777); step("R5 stage left");
    drive(0, 0, 0, 1, 4000000, -4000000); step("R5 output held");
    drive(1, 1, 9'h040, 0, 0, 0); step("R5 stage right");
    drive(0, 1, 0, 1, -222222, 333333); step("R5 right held");

    // R6 + R7: commit through right address alongside a valid sample
    drive(1, 1, 9'h180, 1, 6000000, 6000000); step("R7 collision old gain");
    drive(0, 0, 0, 1, 6000000, 6000000); step("R6 new gain");
    // R2: left is now muted
    for (int i = 0; i < 4; i++) begin
      drive(0, 0, 0, 1, int'($urandom), int'($urandom)); step("R2 mute");
    end

    // R8: idle cycles hold data
    drive(0, 0, 0, 0, 99, 99); step("R8 idle");
    drive(0, 0, 0, 0, -5, 7); step("R8 idle hold");

    // R9: ignored addresses, even with commit flag
    drive(1, 2, 9'h155, 1, 1000000, 1000000); step("R9 addr2 commit");
    drive(1, 3, 9'h1AA, 1, -1000000, 1000000); step("R9 addr3 commit");
    drive(0, 2, 0, 1, 2000000, 2000000); step("R9 readback");

    // R4: sweep codes, commit through left address with a sample
    for (int c = 1; c < 256; c += 17) begin
      drive(1, 1, 255 - c, 1, int'($urandom), int'($urandom)); step("R4 stage");
      drive(1, 0, 9'h100 | c, 1, int'($urandom), int'($urandom)); step("R7 left commit");
      drive(0, 0, 0, 1, 8388607, -8388608); step("R4 extremes");
      drive(0, 1, 0, 1, int'($urandom), int'($urandom)); step("R4 random");
    end
    drive(1, 0, 9'h101, 1, -8388608, 8388607); step("R4 stage min");
    drive(0, 0, 0, 1, -8388608, 8388607); step("R4 code1");

    // R6: mute both then restore with a single commit
    drive(1, 0, 9'h000, 1, 100, 100); step("R6 stage");
    drive(1, 1, 9'h100, 1, 100, 100); step("R6 commit mute");
    drive(1, 0, 9'h0FF, 1, 300, 300); step("R5 stage no commit");
    drive(1, 1, 9'h1FF, 1, 400, 400); step("R6 commit unity");
    drive(0, 0, 0, 1, -12345, 54321); step("R3 restored");
    drive(0, 0, 0, 0, 0, 0); step("R8 final idle");
    finish();
  end
endmodule